// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block watches a 24-bit bus address and drives one active-low select line per channel. Each channel owns a 16-bit base register and a small option register. The base register holds the upper address bits of the channel's region and a 3-bit size code. The size code sets the span of the region, from 2 Kbyte to 1 Mbyte, and so sets which low address bits drop out of the compare. A select line goes low when the address strobe is high, the channel is enabled and the compared bits agree.

Channel 0 is the boot channel. It leaves reset enabled, with a base of zero and the 1-Mbyte code, so the first instruction fetches from address zero reach a boot memory without any setup. Its port-width bit takes the level of `boot_wide_i` while reset is held. Any channel can also raise a one-cycle internal acknowledge after a new strobe hits its region. This works whether or not its select pin is enabled, so the acknowledge also serves regions whose pin does another job. Software reads and writes all registers through a small synchronous register port.

Top module: `cs_decoder`

## Requirements
- R1: A base register write stores address bits 23..11 in bits 15..3 and the size code in bits 2..0, and reading the same channel returns the written 16-bit value.
- R2: Size codes 0 to 7 give regions of 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes, so the lowest compared address bit is 11, 13, 14, 16, 17, 18, 19 and 20 respectively.
- R3: Address bits below the region size take no part in the compare, and neither do the base bits in those positions. The last byte of a region selects; the first byte past it does not.
- R4: `cs_n_o` is active-low and combinational on the address and strobe. All lines stay high while `addr_valid_i` is low.
- R5: Option bit 0 enables a channel's select line. With it clear, the line stays high even on a matching address.
- R6: After reset, channel 0 reads base 0x0007 (base zero, 1-Mbyte code), and its option reads enable set, with the width bit equal to `boot_wide_i` as held during reset. All other channels read zero.
- R7: Channels whose regions overlap each drive their own line low on the same address.
- R8: `iack_o` is high for exactly the one cycle after the clock edge at which `addr_valid_i` is first seen high. It goes high only if the address hits a channel whose option bit 2 is set, and this holds regardless of option bit 0.
- R9: The option register holds enable in bit 0, port width in bit 1 and acknowledge enable in bit 2. Bits 15..3 read zero.
- R10: A register index at or above the channel count ignores writes and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_wide_i | input | 1 | Boot channel width strap, sampled during reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_opt_i | input | 1 | 1 selects option register, 0 selects base register |
| reg_idx_i | input | IDX_W | Channel index of the register access |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on index and select |
| addr_i | input | 24 | Bus address |
| addr_valid_i | input | 1 | Address strobe |
| cs_n_o | output | NUM_CS | Active-low select per channel |
| iack_o | output | 1 | Internal acknowledge pulse |

## Verification
The bench builds the decoder with NUM_CS set to 3, so the 2-bit index has one unused code, 3. That code tests whether writes there are dropped and reads return zero. Three channels are still enough to run the boot channel beside two general channels. The size sweep, the overlap of two regions and the acknowledge with the select disabled all run on the general channels, while the boot region stays fixed at its reset setting.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int ADDR_W   = 24;
    localparam int BASE_LSB = 11;
    localparam int BASE_W   = ADDR_W - BASE_LSB;
    localparam int SIZE_W   = 3;
    localparam int REG_W    = BASE_W + SIZE_W;

    typedef enum logic [SIZE_W-1:0] {
        BLK_2K   = 3'd0,
        BLK_8K   = 3'd1,
        BLK_16K  = 3'd2,
        BLK_64K  = 3'd3,
        BLK_128K = 3'd4,
        BLK_256K = 3'd5,
        BLK_512K = 3'd6,
        BLK_1M   = 3'd7
    } blk_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        blk_e              size;
    } bar_t;

    typedef struct packed {
        logic iack_en;
        logic wide;
        logic en;
    } opt_t;

    localparam int OPT_W = $bits(opt_t);

    function automatic int low_bit(blk_e code);
        case (code)
            BLK_2K:   return 11;
            BLK_8K:   return 13;
            BLK_16K:  return 14;
            BLK_64K:  return 16;
            BLK_128K: return 17;
            BLK_256K: return 18;
            BLK_512K: return 19;
            default:  return 20;
        endcase
    endfunction

    function automatic logic [BASE_W-1:0] cmp_mask(blk_e code);
        logic [BASE_W-1:0] m;
        int lb;
        lb = low_bit(code);
        for (int k = 0; k < BASE_W; k++) begin
            m[k] = ((k + BASE_LSB) >= lb);
        end
        return m;
    endfunction

endpackage

// File: rtl/cs_dec_regs.sv
module cs_dec_regs
    import cs_dec_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      boot_wide_i,
    input  logic                      we_i,
    input  logic                      sel_opt_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    output bar_t [NUM_CS-1:0]         bars_o,
    output opt_t [NUM_CS-1:0]         opts_o
);

    for (genvar ch = 0; ch < NUM_CS; ch++) begin : g_ch
        logic wr_hit;
        assign wr_hit = we_i && (idx_i == IDX_W'(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                if (ch == 0) begin
                    bars_o[ch] <= '{base: '0, size: BLK_1M};
                    opts_o[ch] <= '{iack_en: 1'b0, wide: boot_wide_i, en: 1'b1};
                end else begin
                    bars_o[ch] <= '{base: '0, size: BLK_2K};
                    opts_o[ch] <= '0;
                end
            end else if (wr_hit) begin
                if (sel_opt_i) begin
                    opts_o[ch] <= opt_t'(wdata_i[OPT_W-1:0]);
                end else begin
                    bars_o[ch] <= bar_t'(wdata_i);
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int ch = 0; ch < NUM_CS; ch++) begin
            if (idx_i == IDX_W'(ch)) begin
                rdata_o = sel_opt_i ? REG_W'(opts_o[ch]) : REG_W'(bars_o[ch]);
            end
        end
    end

endmodule

// File: rtl/cs_dec_match.sv
module cs_dec_match
    import cs_dec_pkg::*;
(
    input  bar_t              bar_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    logic [BASE_W-1:0] diff;

    always_comb begin
        diff  = (addr_i[ADDR_W-1:BASE_LSB] ^ bar_i.base) & cmp_mask(bar_i.size);
        hit_o = (diff == '0);
    end

endmodule

// File: rtl/cs_dec_ack.sv
module cs_dec_ack #(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [NUM_CS-1:0] ack_hit_i,
    output logic              iack_o
);

    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            iack_o  <= 1'b0;
        end else begin
            valid_q <= valid_i;
            iack_o  <= valid_i && !valid_q && (|ack_hit_i);
        end
    end

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_dec_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_wide_i,
    input  logic                  reg_we_i,
    input  logic                  reg_opt_i,
    input  logic [IDX_W-1:0]      reg_idx_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  addr_valid_i,
    output logic [NUM_CS-1:0]     cs_n_o,
    output logic                  iack_o
);

    bar_t [NUM_CS-1:0] bars;
    opt_t [NUM_CS-1:0] opts;
    logic [NUM_CS-1:0] hit;
    logic [NUM_CS-1:0] ack_hit;
    logic [NUM_CS-1:0] en_vec;
    logic [BASE_W-1:0] boot_base;
    logic [SIZE_W-1:0] boot_size;

    cs_dec_regs #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .boot_wide_i (boot_wide_i),
        .we_i        (reg_we_i),
        .sel_opt_i   (reg_opt_i),
        .idx_i       (reg_idx_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .bars_o      (bars),
        .opts_o      (opts)
    );

    for (genvar ch = 0; ch < NUM_CS; ch++) begin : g_match
        cs_dec_match u_match (
            .bar_i  (bars[ch]),
            .addr_i (addr_i),
            .hit_o  (hit[ch])
        );
        assign en_vec[ch]  = opts[ch].en;
        assign ack_hit[ch] = hit[ch] && opts[ch].iack_en;
        assign cs_n_o[ch]  = !(addr_valid_i && hit[ch] && opts[ch].en);
    end

    assign boot_base = bars[0].base;
    assign boot_size = bars[0].size;

    cs_dec_ack #(.NUM_CS(NUM_CS)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (addr_valid_i),
        .ack_hit_i (ack_hit),
        .iack_o    (iack_o)
    );

endmodule

// File: rtl/cs_dec_chk.sv
module cs_dec_chk
    import cs_dec_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              addr_valid_i,
    input logic [NUM_CS-1:0] cs_n_o,
    input logic              iack_o,
    input logic [NUM_CS-1:0] en_vec,
    input logic [BASE_W-1:0] boot_base,
    input logic [SIZE_W-1:0] boot_size
);

    AST_CS_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !addr_valid_i |-> (&cs_n_o)); // R4

    for (genvar ch = 0; ch < NUM_CS; ch++) begin : g_en
        AST_CS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
            !cs_n_o[ch] |-> en_vec[ch]); // R5
    end

    AST_BOOT_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (boot_base == '0 && boot_size == 3'b111)); // R6

    AST_BOOT_TOP: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o[0] |-> (addr_i[ADDR_W-1:20] == boot_base[BASE_W-1:20-BASE_LSB])); // R2

    AST_IACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        iack_o |=> !iack_o); // R8

    AST_IACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        iack_o |-> $past(addr_valid_i)); // R8

endmodule

bind cs_decoder cs_dec_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (addr_i),
    .addr_valid_i (addr_valid_i),
    .cs_n_o       (cs_n_o),
    .iack_o       (iack_o),
    .en_vec       (en_vec),
    .boot_base    (boot_base),
    .boot_size    (boot_size)
);

// File: tb/cs_decoder_tb.sv
module cs_decoder_tb;

    localparam int N     = 3;
    localparam int IDX_W = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        boot_wide_i;
    logic        reg_we_i;
    logic        reg_opt_i;
    logic [IDX_W-1:0] reg_idx_i;
    logic [15:0] reg_wdata_i;
    logic [15:0] reg_rdata_o;
    logic [23:0] addr_i;
    logic        addr_valid_i;
    logic [N-1:0] cs_n_o;
    logic        iack_o;

    always #2 clk = ~clk;

    cs_decoder #(.NUM_CS(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .boot_wide_i  (boot_wide_i),
        .reg_we_i     (reg_we_i),
        .reg_opt_i    (reg_opt_i),
        .reg_idx_i    (reg_idx_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .addr_i       (addr_i),
        .addr_valid_i (addr_valid_i),
        .cs_n_o       (cs_n_o),
        .iack_o       (iack_o)
    );

    typedef struct {
        logic [N-1:0] cs;
        logic         ack;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic done   = 1'b0;

    logic [15:0] m_bar [N];
    logic [2:0]  m_opt [N];
    logic        m_prev;

    function automatic int lb_of(logic [2:0] c);
        case (c)
            3'd0: return 11; 3'd1: return 13; 3'd2: return 14; 3'd3: return 16;
            3'd4: return 17; 3'd5: return 18; 3'd6: return 19; default: return 20;
        endcase
    endfunction

    function automatic logic m_hit(int ch, logic [23:0] a);
        int lb;
        logic [23:0] b;
        lb = lb_of(m_bar[ch][2:0]);
        b  = {m_bar[ch][15:3], 11'b0};
        return (a >> lb) == (b >> lb);
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [23:0] a, logic v, string tag);
        exp_t e;
        logic anyack;
        @(negedge clk);
        reg_we_i     = 1'b0;
        addr_i       = a;
        addr_valid_i = v;
        anyack = 1'b0;
        for (int ch = 0; ch < N; ch++) begin
            e.cs[ch] = !(v && m_hit(ch, a) && m_opt[ch][0]);
            if (m_hit(ch, a) && m_opt[ch][2]) anyack = 1'b1;
        end
        e.ack  = v && !m_prev && anyack;
        e.tag  = tag;
        m_prev = v;
        q.push_back(e);
    endtask

    task automatic wr(logic [1:0] idx, logic opt, logic [15:0] d);
        @(negedge clk);
        addr_valid_i = 1'b0;
        m_prev       = 1'b0;
        reg_we_i     = 1'b1;
        reg_idx_i    = idx;
        reg_opt_i    = opt;
        reg_wdata_i  = d;
        if (idx < N) begin
            if (opt) m_opt[idx] = d[2:0];
            else     m_bar[idx] = d;
        end
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(logic [1:0] idx, logic opt, logic [15:0] exp, string tag);
        @(negedge clk);
        reg_we_i  = 1'b0;
        reg_idx_i = idx;
        reg_opt_i = opt;
        #1;
        check(32'(reg_rdata_o), 32'(exp), tag);
    endtask

    task automatic do_reset(logic wide);
        @(negedge clk);
        rst          = 1'b1;
        boot_wide_i  = wide;
        addr_valid_i = 1'b0;
        reg_we_i     = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_prev = 1'b0;
        m_bar[0] = 16'h0007; m_opt[0] = {1'b0, wide, 1'b1};
        for (int ch = 1; ch < N; ch++) begin
            m_bar[ch] = '0; m_opt[ch] = '0;
        end
    endtask

    // monitor: pops one expected item per driven cycle after the following edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(32'(cs_n_o), 32'(e.cs), {e.tag, " cs_n"});
                check(32'(iack_o), 32'(e.ack), {e.tag, " iack"});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; boot_wide_i = 1'b0; reg_we_i = 1'b0; reg_opt_i = 1'b0;
        reg_idx_i = '0; reg_wdata_i = '0; addr_i = '0; addr_valid_i = 1'b0;
        do_reset(1'b0);

        // R6 reset state
        rd(0, 0, 16'h0007, "R6 boot base");
        rd(0, 1, 16'h0001, "R6 boot option");
        rd(1, 0, 16'h0000, "R6 ch1 base");
        rd(2, 1, 16'h0000, "R6 ch2 option");

        // R4 strobe gating, R3 boot region edges
        drive(24'h000100, 1'b0, "R4 no strobe");
        drive(24'h000100, 1'b1, "R4 boot hit");
        drive(24'h0FFFFF, 1'b1, "R3 boot last byte");
        drive(24'h100000, 1'b1, "R3 boot past end");
        drive(24'h000000, 1'b0, "R4 idle");

        // R1 R9 program channel 1: 8K at 0x200000
        wr(1, 0, 16'h2001);
        wr(1, 1, 16'h0003);
        rd(1, 0, 16'h2001, "R1 ch1 base readback");
        rd(1, 1, 16'h0003, "R9 ch1 option readback");
        wr(1, 1, 16'hFFF9);
        rd(1, 1, 16'h0001, "R9 upper option bits zero");
        drive(24'h201FFF, 1'b1, "R3 ch1 last byte");
        drive(24'h202000, 1'b1, "R3 ch1 past end");
        drive(24'h000000, 1'b0, "R4 idle");

        // R2 size sweep on channel 2
        wr(2, 1, 16'h0001);
        for (int c = 0; c < 8; c++) begin
            int lb;
            lb = lb_of(3'(c));
            wr(2, 0, 16'h4000 | 16'(c));
            drive(24'h400000 + 24'((1 << lb) - 1), 1'b1, "R2 size last byte");
            drive(24'h400000 + 24'(1 << lb), 1'b1, "R2 size past end");
            drive(24'h000000, 1'b0, "R4 idle");
        end

        // R3 base bits under the region are ignored
        wr(2, 0, 16'h4FFF);
        drive(24'h400000, 1'b1, "R3 masked base bits");
        drive(24'h000000, 1'b0, "R4 idle");

        // R5 enable clear, R8 ack with pin disabled
        wr(1, 1, 16'h0004);
        drive(24'h200010, 1'b1, "R5 R8 disabled pin ack");
        drive(24'h200010, 1'b1, "R8 held strobe no second ack");
        drive(24'h200010, 1'b0, "R4 idle");
        drive(24'h300000, 1'b1, "R8 miss no ack");
        drive(24'h000000, 1'b0, "R4 idle");

        // R7 overlap
        wr(1, 1, 16'h0001);
        wr(2, 0, 16'h2001);
        drive(24'h200800, 1'b1, "R7 overlap both low");
        drive(24'h000000, 1'b0, "R4 idle");

        // R10 index past channel count
        wr(3, 0, 16'hABCD);
        wr(3, 1, 16'h0007);
        rd(3, 0, 16'h0000, "R10 base read zero");
        rd(3, 1, 16'h0000, "R10 option read zero");
        rd(0, 0, 16'h0007, "R10 boot base untouched");
        rd(2, 0, 16'h2001, "R10 ch2 base untouched");

        // R6 wide strap
        do_reset(1'b1);
        rd(0, 1, 16'h0003, "R6 boot wide strap");
        rd(1, 1, 16'h0000, "R6 ch1 option cleared");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule